// File: doc/BRIEF.md
# Bus Handoff Arbiter

This block decides when the processor gives up its external bus to another master and when it takes the bus back. It watches two asynchronous inputs from the outside world: a bus request and an acknowledge that the other master has taken the bus. It produces two outputs. One is a bus grant pin. The other is a release control that keeps the processor's own bus drivers in the high-impedance state while it is asserted.

Both asynchronous inputs are resynchronized before a five-state controller acts on them. The controller moves through the states idle, grant, hold, drop and wait. The grant pin is retimed so that it changes on the falling clock edge that follows the state change. The release control changes right after the rising edge, so the processor's bus engine can drive the bus again as soon as the controller reaches idle.

A read-modify-write indicator from the processor core masks the request. While the indicator is high, no locked sequence can be broken into.

Top module: `handoff_arb`

## Requirements
- R1: While `rstN` is low, the controller is held in idle and both `busGrantOut` and `driversOff` are 0, whatever the request and acknowledge inputs are.
- R2: `busReqIn` and `grantAckIn` each pass through `SYNC_STAGES` (default 2) flops. With the default, a request first held high before rising edge E1 reaches the grant state at rising edge E3, and `driversOff` is still 0 after E1 and E2.
- R3: In idle, the controller stays in idle while the resynchronized request is low, even when the acknowledge is high. Both outputs stay 0.
- R4: A resynchronized request seen in idle moves the controller to grant, where grant and release are both 1. On the next edge it moves to hold without any condition, so grant stays 1 for at least two cycles.
- R5: The controller leaves hold when the resynchronized acknowledge is 1 or the resynchronized request is 0. The next state, drop, has grant 0 and release 1. One edge later it reaches wait, where release is still 1.
- R6: In wait, release stays 1 while the resynchronized acknowledge is 1. When the acknowledge is 0 and the request is 0, the controller returns to idle and `driversOff` falls to 0.
- R7: `busGrantOut` equals the internal grant value. It changes only on the falling clock edge that follows the rising edge which changed the internal grant, so just after that rising edge it still shows the old value.
- R8: `driversOff` is 1 exactly in the states grant, hold, drop and wait, and it changes just after the rising edge that changes the state.
- R9: When `rmwActive` is 1 at a rising edge, the resynchronized request is taken as 0 at that edge. A request that arrives from idle during a read-modify-write window is therefore granted only at the first edge at which `rmwActive` is 0.
- R10: In wait, if the acknowledge is 0 and the request is 1, the controller goes straight to grant and sets grant back to 1 without passing through idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on the rising edge and the grant pin is retimed on the falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busReqIn | input | 1 | Bus request from an external master, asynchronous, active high |
| grantAckIn | input | 1 | Acknowledge from the external master that it has taken the bus, asynchronous, active high |
| rmwActive | input | 1 | High while the core runs a read-modify-write sequence; masks the request |
| busGrantOut | output | 1 | Bus grant pin, updated on the falling edge |
| driversOff | output | 1 | Release control; high keeps the processor's bus drivers off the bus |

## Verification
A normal handoff is run through cycle by cycle: request, acknowledge, then the acknowledge is dropped. This checks that the synchronizer latency and every state's output pair match the expected cycle. A request withdrawn before any acknowledge exercises the second exit from hold, which the normal handoff leaves untouched. A re-request in wait separates the direct return to grant from a pass through idle. A request held during a read-modify-write window, and an acknowledge raised alone in idle, show that neither input can start a handoff by itself. Long runs of random request, acknowledge and read-modify-write levels are compared every cycle against a bench model, which catches mismatches in the overlapping input combinations that the directed cases do not reach.

// File: rtl/handoff_pkg.sv
package handoff_pkg;

  typedef enum logic [2:0] {
    ARB_IDLE  = 3'd0,
    ARB_GRANT = 3'd1,
    ARB_HOLD  = 3'd2,
    ARB_DROP  = 3'd3,
    ARB_WAIT  = 3'd4
  } arbState_t;

  typedef struct packed {
    logic grantOn;
    logic releaseOn;
  } arbStrobe_t;

endpackage

// File: rtl/handoff_sync.sv
module handoff_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/handoff_ctrl.sv
module handoff_ctrl
  import handoff_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqEff,
  input  logic       ackSync,
  output arbStrobe_t strobe
);

  arbState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ARB_IDLE:  if (reqEff) stateD = ARB_GRANT;
      ARB_GRANT: stateD = ARB_HOLD;
      ARB_HOLD:  if (ackSync || !reqEff) stateD = ARB_DROP;
      ARB_DROP:  stateD = ARB_WAIT;
      ARB_WAIT: begin
        if (!ackSync) stateD = reqEff ? ARB_GRANT : ARB_IDLE;
      end
      default:   stateD = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ARB_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe = '0;
    unique case (stateQ)
      ARB_GRANT, ARB_HOLD: begin
        strobe.grantOn   = 1'b1;
        strobe.releaseOn = 1'b1;
      end
      ARB_DROP, ARB_WAIT: begin
        strobe.grantOn   = 1'b0;
        strobe.releaseOn = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/handoff_dp.sv
module handoff_dp
  import handoff_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReqIn,
  input  logic       grantAckIn,
  input  logic       rmwActive,
  input  arbStrobe_t strobe,
  output logic       reqEff,
  output logic       ackSync,
  output logic       busGrantOut,
  output logic       driversOff
);

  localparam int SYNC_WIDTH = 2;

  logic [SYNC_WIDTH-1:0] rawIn;
  logic [SYNC_WIDTH-1:0] syncIn;
  logic                  grantPinQ;

  assign rawIn = {grantAckIn, busReqIn};

  handoff_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (SYNC_WIDTH)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rawIn),
    .syncOut(syncIn)
  );

  // read-modify-write masks the resynchronized request
  assign reqEff  = syncIn[0] & ~rmwActive;
  assign ackSync = syncIn[1];

  // grant pin retimed to the falling edge after the state change
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) grantPinQ <= 1'b0;
    else       grantPinQ <= strobe.grantOn;
  end

  assign busGrantOut = grantPinQ;
  assign driversOff  = strobe.releaseOn;

endmodule

// File: rtl/handoff_arb.sv
module handoff_arb
  import handoff_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReqIn,
  input  logic grantAckIn,
  input  logic rmwActive,
  output logic busGrantOut,
  output logic driversOff
);

  arbStrobe_t strobe;
  logic       reqEff;
  logic       ackSync;
  logic       grantInt;

  handoff_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .reqEff (reqEff),
    .ackSync(ackSync),
    .strobe (strobe)
  );

  handoff_dp #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busReqIn   (busReqIn),
    .grantAckIn (grantAckIn),
    .rmwActive  (rmwActive),
    .strobe     (strobe),
    .reqEff     (reqEff),
    .ackSync    (ackSync),
    .busGrantOut(busGrantOut),
    .driversOff (driversOff)
  );

  assign grantInt = strobe.grantOn;

endmodule

module handoff_arb_chk (
  input logic clk,
  input logic rstN,
  input logic gInt,
  input logic tInt,
  input logic ackSync,
  input logic rmwActive,
  input logic busGrantOut
);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!tInt && !busGrantOut);
    end
  end

  assert_grant_two_cycles_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gInt) |=> gInt);

  assert_drop_keeps_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gInt) |-> tInt);

  assert_release_needs_ack_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tInt) |-> !$past(ackSync));

  assert_pin_tracks_grant_R7: assert property (@(posedge clk) disable iff (!rstN)
    busGrantOut == gInt);

  assert_grant_implies_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    gInt |-> tInt);

  assert_rmw_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!tInt && rmwActive) |=> !tInt);

endmodule

bind handoff_arb handoff_arb_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .gInt       (grantInt),
  .tInt       (driversOff),
  .ackSync    (ackSync),
  .rmwActive  (rmwActive),
  .busGrantOut(busGrantOut)
);

// File: tb/sim_handoff_arb.sv
`timescale 1ns/1ps
module sim_handoff_arb;

  localparam int S_IDLE = 0, S_GRANT = 1, S_HOLD = 2, S_DROP = 3, S_WAIT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReqIn = 1'b0;
  logic grantAckIn = 1'b0;
  logic rmwActive = 1'b0;
  logic busGrantOut;
  logic driversOff;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  handoff_arb u0 (
    .clk        (clk),
    .rstN       (rstN),
    .busReqIn   (busReqIn),
    .grantAckIn (grantAckIn),
    .rmwActive  (rmwActive),
    .busGrantOut(busGrantOut),
    .driversOff (driversOff)
  );

  // bench model built from the requirements
  function automatic int nextState(int s, bit r, bit a);
    case (s)
      S_IDLE:  return r ? S_GRANT : S_IDLE;
      S_GRANT: return S_HOLD;
      S_HOLD:  return (a || !r) ? S_DROP : S_HOLD;
      S_DROP:  return S_WAIT;
      S_WAIT:  return a ? S_WAIT : (r ? S_GRANT : S_IDLE);
      default: return S_IDLE;
    endcase
  endfunction

  function automatic bit expRelease(int s);
    return s != S_IDLE;
  endfunction

  function automatic bit expGrant(int s);
    return (s == S_GRANT) || (s == S_HOLD);
  endfunction

  logic [1:0] mReq, mAck;
  int mState;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReq   <= '0;
      mAck   <= '0;
      mState <= S_IDLE;
    end else begin
      mReq   <= {mReq[0], busReqIn};
      mAck   <= {mAck[0], grantAckIn};
      mState <= nextState(mState, mReq[1] && !rmwActive, mAck[1]);
    end
  end

  task automatic check(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // one cycle: rising edge, check release; falling edge, check pin
  task automatic step(string tag, logic expT, logic expG);
    @(posedge clk); #1;
    check({tag, " driversOff"}, driversOff, expT);
    @(negedge clk); #1;
    check({tag, " busGrantOut"}, busGrantOut, expG);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset holds idle while inputs are active
    busReqIn = 1'b1; grantAckIn = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset driversOff", driversOff, 1'b0);
    check("R1 reset busGrantOut", busGrantOut, 1'b0);
    busReqIn = 1'b0; grantAckIn = 1'b0;
    @(negedge clk); #1;
    rstN = 1'b1;
    repeat (4) step("R1 after reset", 1'b0, 1'b0);

    // R3: acknowledge alone keeps idle
    grantAckIn = 1'b1;
    repeat (5) step("R3 ack alone", 1'b0, 1'b0);
    grantAckIn = 1'b0;
    repeat (3) step("R3 settle", 1'b0, 1'b0);

    // normal release sequence
    busReqIn = 1'b1;
    step("R2 sync stage1", 1'b0, 1'b0);
    step("R2 sync stage2", 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R8 release at grant", driversOff, 1'b1);
    check("R7 pin before falling edge", busGrantOut, 1'b0);
    @(negedge clk); #1;
    check("R7 pin after falling edge", busGrantOut, 1'b1);
    grantAckIn = 1'b1; busReqIn = 1'b0;
    step("R4 hold", 1'b1, 1'b1);
    step("R4 hold2", 1'b1, 1'b1);
    step("R5 drop", 1'b1, 1'b0);
    step("R5 wait", 1'b1, 1'b0);
    step("R6 wait with ack", 1'b1, 1'b0);
    grantAckIn = 1'b0;
    step("R6 wait ack sync1", 1'b1, 1'b0);
    step("R6 wait ack sync2", 1'b1, 1'b0);
    step("R6 back to idle", 1'b0, 1'b0);
    repeat (2) step("R6 idle", 1'b0, 1'b0);

    // request withdrawn before acknowledge
    busReqIn = 1'b1;
    step("R2 w1", 1'b0, 1'b0);
    step("R2 w2", 1'b0, 1'b0);
    step("R4 w grant", 1'b1, 1'b1);
    busReqIn = 1'b0;
    step("R4 w hold", 1'b1, 1'b1);
    step("R5 w hold2", 1'b1, 1'b1);
    step("R5 w drop", 1'b1, 1'b0);
    step("R5 w wait", 1'b1, 1'b0);
    step("R6 w idle", 1'b0, 1'b0);
    repeat (2) step("R6 w settle", 1'b0, 1'b0);

    // request masked by read-modify-write window
    rmwActive = 1'b1; busReqIn = 1'b1;
    for (int i = 0; i < 6; i++) step("R9 masked", 1'b0, 1'b0);
    rmwActive = 1'b0;
    step("R9 granted after window", 1'b1, 1'b1);
    busReqIn = 1'b0;
    step("R9 hold", 1'b1, 1'b1);
    step("R9 hold2", 1'b1, 1'b1);
    step("R9 drop", 1'b1, 1'b0);
    step("R9 wait", 1'b1, 1'b0);
    step("R9 idle", 1'b0, 1'b0);
    repeat (2) step("R9 settle", 1'b0, 1'b0);

    // re-request while in wait
    busReqIn = 1'b1;
    step("R10 s1", 1'b0, 1'b0);
    step("R10 s2", 1'b0, 1'b0);
    step("R10 grant", 1'b1, 1'b1);
    grantAckIn = 1'b1; busReqIn = 1'b0;
    step("R10 hold", 1'b1, 1'b1);
    step("R10 hold2", 1'b1, 1'b1);
    step("R10 drop", 1'b1, 1'b0);
    step("R10 wait", 1'b1, 1'b0);
    grantAckIn = 1'b0; busReqIn = 1'b1;
    step("R10 wait a", 1'b1, 1'b0);
    step("R10 wait b", 1'b1, 1'b0);
    step("R10 regrant no idle", 1'b1, 1'b1);
    step("R10 rehold", 1'b1, 1'b1);
    busReqIn = 1'b0;
    step("R10 rehold2", 1'b1, 1'b1);
    step("R10 rehold3", 1'b1, 1'b1);
    step("R10 redrop", 1'b1, 1'b0);
    step("R10 rewait", 1'b1, 1'b0);
    step("R10 idle", 1'b0, 1'b0);

    // random levels against bench model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      check("R8 random driversOff", driversOff, expRelease(mState));
      check("R7 random busGrantOut", busGrantOut, expGrant(mState));
      if (($urandom % 8) == 0) busReqIn   = ~busReqIn;
      if (($urandom % 8) == 0) grantAckIn = ~grantAckIn;
      if (($urandom % 16) == 0) rmwActive = ~rmwActive;
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule